// File: doc/BRIEF.md
# Watchdog Reset Gate with Sticky Cause Flag

This block sits on the power-management side of a chip, between the reset request of a watchdog timer and the system reset controller. It decides whether a watchdog request is passed on as a system reset request. It also drives the enable line that the watchdog counter needs in order to count, and it keeps a sticky flag recording that a watchdog reset has gone out.

Three control bits gate the path. The first is a reset mask whose meaning is fixed by a parameter. With the default polarity a set bit lets the reset through. With the other polarity a set bit blocks it. The second is an auto-disable bit. While it is set, a request is dropped for as long as the associated processor's reset input is held. The third is the counter-enable bit, which drives the enable output. A small register bus reads and writes these bits and reads the cause flag. Writing 1 to the cause flag clears it.

All state is reset only by power-on reset, so the cause flag survives the system reset that the block itself requests. To arm the watchdog, software clears auto-disable, unmasks the reset and sets counter-enable. To disarm it, software does the opposite.

Top module: `wdg_rst_gate`

## Requirements
- R1: After power-on reset the block is in this state. The counter-enable output is 0, the reset output is 0, the cause flag is 0 and auto-disable is 0. The mask is in the blocking state: the mask bit reads 0 when MASK_INV=1 and reads 1 when MASK_INV=0.
- R2: The counter-enable bit is bit 7 of the register at offset 0x08. The `wdg_cnt_en_o` output follows this bit from the clock edge of the write onwards, and it changes on no other event.
- R3: The mask bit is bit 2 of the register at offset 0x00. With MASK_INV=1 the reset is allowed only while this bit is 1. With MASK_INV=0 the reset is allowed only while this bit is 0.
- R4: The auto-disable bit is bit 2 of the register at offset 0x04. While it is 1 and `cpu_in_rst_i` is high, a watchdog request is ignored.
- R5: `sys_wdg_rst_o` is registered. It is high in the cycle after a clock edge at which the request was high and both the mask and auto-disable allowed it. Otherwise it is low.
- R6: The cause flag is bit 0 of the register at offset 0x0C. It is set on every edge at which a reset is passed on, and it holds its value until a write with bit 0 = 1 clears it. Writing 0 has no effect. If a set and a clear fall on the same edge, the set wins.
- R7: A read returns each control bit at its own position and 0 in every other bit. An unmapped offset reads as 0.
- R8: A write changes only the addressed bit. A write to an unmapped offset, or a write that touches only other bit positions, leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write (1) or read (0) |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| wdg_req_i | input | 1 | Reset request from the watchdog |
| cpu_in_rst_i | input | 1 | Associated processor is held in reset |
| wdg_cnt_en_o | output | 1 | Counter enable to the watchdog |
| sys_wdg_rst_o | output | 1 | Gated reset request to the reset controller |

## Verification
The assertions check on every cycle that a blocked mask, an active auto-disable condition or an idle request leads to a low reset output on the next cycle. They also check that every outgoing reset coincides with a set cause flag, that the flag only falls after a clearing write, and that the counter enable moves only on a write to its register. The sequences themselves can only be shown by the bench's scenarios. These are the polarity difference between the two parameter variants, the set-over-clear priority of the flag, the arm and disarm write order, and the fact that unmapped or other-bit writes leave state unchanged. In those scenarios a behavioural model is compared with both variants on every clock.

// File: rtl/wdg_gate_pkg.sv
package wdg_gate_pkg;

    // Register file contents of the reset gate
    typedef struct packed {
        logic mask_bit;   // stored mask bit, meaning set by MASK_INV
        logic autodis;    // drop request while processor is in reset
        logic cnt_en;     // watchdog counter enable
        logic cause;      // sticky: a watchdog reset went out
    } gate_regs_t;

    typedef struct packed {
        logic rst_req;
    } gate_path_t;

endpackage

// File: rtl/wdg_gate_regs.sv
module wdg_gate_regs
    import wdg_gate_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int OFF_MASK    = 'h00,
    parameter int OFF_AUTODIS = 'h04,
    parameter int OFF_CNTEN   = 'h08,
    parameter int OFF_STAT    = 'h0C,
    parameter int MASK_BIT    = 2,
    parameter int CNT_BIT     = 7,
    parameter int STAT_BIT    = 0,
    parameter bit MASK_INV    = 1'b1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cause_set_i,
    output logic              mask_bit_o,
    output logic              autodis_o,
    output logic              cnt_en_o,
    output logic              cause_o
);

    localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFF_MASK);
    localparam logic [ADDR_W-1:0] A_AUTODIS = ADDR_W'(OFF_AUTODIS);
    localparam logic [ADDR_W-1:0] A_CNTEN   = ADDR_W'(OFF_CNTEN);
    localparam logic [ADDR_W-1:0] A_STAT    = ADDR_W'(OFF_STAT);
    // Reset leaves the mask in its blocking state
    localparam logic MASK_RST = MASK_INV ? 1'b0 : 1'b1;

    gate_regs_t r_d, r_q;
    logic wr_en, wr_mask, wr_autodis, wr_cnten, cause_clr;

    always_comb begin
        wr_en      = bus_sel && bus_we;
        wr_mask    = wr_en && (bus_addr == A_MASK);
        wr_autodis = wr_en && (bus_addr == A_AUTODIS);
        wr_cnten   = wr_en && (bus_addr == A_CNTEN);
        cause_clr  = wr_en && (bus_addr == A_STAT) && bus_wdata[STAT_BIT];

        r_d = r_q;
        if (wr_mask)    r_d.mask_bit = bus_wdata[MASK_BIT];
        if (wr_autodis) r_d.autodis  = bus_wdata[MASK_BIT];
        if (wr_cnten)   r_d.cnt_en   = bus_wdata[CNT_BIT];
        if (cause_clr)   r_d.cause    = 1'b0;
        if (cause_set_i) r_d.cause    = 1'b1;   // set wins over clear
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            r_q.mask_bit <= MASK_RST;
            r_q.autodis  <= 1'b0;
            r_q.cnt_en   <= 1'b0;
            r_q.cause    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_MASK)         bus_rdata[MASK_BIT] = r_q.mask_bit;
        else if (bus_addr == A_AUTODIS) bus_rdata[MASK_BIT] = r_q.autodis;
        else if (bus_addr == A_CNTEN)   bus_rdata[CNT_BIT]  = r_q.cnt_en;
        else if (bus_addr == A_STAT)    bus_rdata[STAT_BIT] = r_q.cause;
    end

    assign mask_bit_o = r_q.mask_bit;
    assign autodis_o  = r_q.autodis;
    assign cnt_en_o   = r_q.cnt_en;
    assign cause_o    = r_q.cause;

    // R2: counter enable moves only through a write to its register
    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!por_n)
        !wr_cnten |=> $stable(cnt_en_o));

    // R6: cause flag falls only after a clearing write
    p_cause_sticky_r6: assert property (@(posedge clk) disable iff (!por_n)
        $fell(cause_o) |-> $past(cause_clr));

    // R6: a set request always leaves the flag set
    p_cause_set_r6: assert property (@(posedge clk) disable iff (!por_n)
        cause_set_i |=> cause_o);

endmodule

// File: rtl/wdg_gate_path.sv
module wdg_gate_path
    import wdg_gate_pkg::*;
#(
    parameter bit MASK_INV = 1'b1
) (
    input  logic clk,
    input  logic por_n,
    input  logic req_i,
    input  logic cpu_in_rst_i,
    input  logic mask_bit_i,
    input  logic autodis_i,
    output logic fire_o,
    output logic rst_req_o
);

    logic allow;
    gate_path_t p_d, p_q;

    generate
        if (MASK_INV) begin : g_set_allows
            assign allow = mask_bit_i;
        end else begin : g_set_blocks
            assign allow = ~mask_bit_i;
        end
    endgenerate

    always_comb begin
        fire_o    = req_i && allow && !(autodis_i && cpu_in_rst_i);
        p_d       = p_q;
        p_d.rst_req = fire_o;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign rst_req_o = p_q.rst_req;

    // R3: a blocking mask keeps the output low on the next cycle
    p_mask_blocks_r3: assert property (@(posedge clk) disable iff (!por_n)
        (MASK_INV ? !mask_bit_i : mask_bit_i) |=> !rst_req_o);

    // R4: auto-disable with processor in reset suppresses the output
    p_autodis_blocks_r4: assert property (@(posedge clk) disable iff (!por_n)
        (autodis_i && cpu_in_rst_i) |=> !rst_req_o);

    // R5: no request, no reset on the next cycle
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!por_n)
        !req_i |=> !rst_req_o);

endmodule

// File: rtl/wdg_rst_gate.sv
module wdg_rst_gate
    import wdg_gate_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int OFF_MASK    = 'h00,
    parameter int OFF_AUTODIS = 'h04,
    parameter int OFF_CNTEN   = 'h08,
    parameter int OFF_STAT    = 'h0C,
    parameter int MASK_BIT    = 2,
    parameter int CNT_BIT     = 7,
    parameter int STAT_BIT    = 0,
    parameter bit MASK_INV    = 1'b1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wdg_req_i,
    input  logic              cpu_in_rst_i,
    output logic              wdg_cnt_en_o,
    output logic              sys_wdg_rst_o
);

    logic mask_bit, autodis, cause, fire;

    wdg_gate_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .OFF_MASK(OFF_MASK), .OFF_AUTODIS(OFF_AUTODIS),
        .OFF_CNTEN(OFF_CNTEN), .OFF_STAT(OFF_STAT),
        .MASK_BIT(MASK_BIT), .CNT_BIT(CNT_BIT), .STAT_BIT(STAT_BIT),
        .MASK_INV(MASK_INV)
    ) u_regs (
        .clk(clk), .por_n(por_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cause_set_i(fire),
        .mask_bit_o(mask_bit), .autodis_o(autodis),
        .cnt_en_o(wdg_cnt_en_o), .cause_o(cause)
    );

    wdg_gate_path #(.MASK_INV(MASK_INV)) u_path (
        .clk(clk), .por_n(por_n),
        .req_i(wdg_req_i), .cpu_in_rst_i(cpu_in_rst_i),
        .mask_bit_i(mask_bit), .autodis_i(autodis),
        .fire_o(fire), .rst_req_o(sys_wdg_rst_o)
    );

    // R6: every outgoing reset is recorded in the cause flag
    p_rst_recorded_r6: assert property (@(posedge clk) disable iff (!por_n)
        sys_wdg_rst_o |-> cause);

endmodule

// File: tb/tb_wdg_rst_gate.sv
module tb_wdg_rst_gate;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 5000;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic wdg_req = 1'b0, cpu_rst = 1'b0;
    logic [31:0] rd_a, rd_b;
    logic cen_a, cen_b, rst_a, rst_b;

    int n_checks = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // dut: set bit allows the reset; dut_pos: set bit blocks it
    wdg_rst_gate dut (
        .clk(clk), .por_n(por_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_a),
        .wdg_req_i(wdg_req), .cpu_in_rst_i(cpu_rst),
        .wdg_cnt_en_o(cen_a), .sys_wdg_rst_o(rst_a));

    wdg_rst_gate #(.MASK_INV(1'b0)) dut_pos (
        .clk(clk), .por_n(por_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_b),
        .wdg_req_i(wdg_req), .cpu_in_rst_i(cpu_rst),
        .wdg_cnt_en_o(cen_b), .sys_wdg_rst_o(rst_b));

    // Behavioural reference: index 0 = inverted polarity, 1 = plain
    bit m_mask[2], m_ad[2], m_cen[2], m_flag[2], m_rst[2];

    always @(posedge clk or negedge por_n) begin
        for (int v = 0; v < 2; v++) begin
            if (!por_n) begin
                m_mask[v] = (v == 1); m_ad[v] = 0; m_cen[v] = 0;
                m_flag[v] = 0; m_rst[v] = 0;
            end else begin
                bit ok, fire, w;
                ok   = (v == 0) ? m_mask[v] : !m_mask[v];
                fire = wdg_req && ok && !(m_ad[v] && cpu_rst);
                w    = bus_sel && bus_we;
                if (w && bus_addr == 8'h00) m_mask[v] = bus_wdata[2];
                if (w && bus_addr == 8'h04) m_ad[v]   = bus_wdata[2];
                if (w && bus_addr == 8'h08) m_cen[v]  = bus_wdata[7];
                if (w && bus_addr == 8'h0C && bus_wdata[0]) m_flag[v] = 0;
                if (fire) m_flag[v] = 1;
                m_rst[v] = fire;
            end
        end
    end

    function automatic logic [31:0] model_rd(int v);
        logic [31:0] r = '0;
        case (bus_addr)
            8'h00: r[2] = m_mask[v];
            8'h04: r[2] = m_ad[v];
            8'h08: r[7] = m_cen[v];
            8'h0C: r[0] = m_flag[v];
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // advance one cycle and compare both variants with the model
    task automatic step();
        @(negedge clk);
        #1;
        check("R5 rst(inv)",  {31'd0, rst_a}, {31'd0, m_rst[0]});
        check("R5 rst(pos)",  {31'd0, rst_b}, {31'd0, m_rst[1]});
        check("R2 cen(inv)",  {31'd0, cen_a}, {31'd0, m_cen[0]});
        check("R2 cen(pos)",  {31'd0, cen_b}, {31'd0, m_cen[1]});
        check("R7 rdata(inv)", rd_a, model_rd(0));
        check("R7 rdata(pos)", rd_b, model_rd(1));
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_sel = 0; bus_we = 0; bus_wdata = '0;
    endtask

    task automatic rd2(input logic [7:0] a, input logic [31:0] ea, input logic [31:0] eb, input string tag);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1;
        check({tag, " (inv)"}, rd_a, ea);
        check({tag, " (pos)"}, rd_b, eb);
        bus_sel = 0;
    endtask

    initial begin
        #(CLK_PERIOD * MAX_CYCLES);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not end, got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed;
        repeat (3) step();
        por_n = 1;
        step();
        // R1: reset state
        check("R1 cen", {30'd0, cen_a, cen_b}, 32'd0);
        check("R1 rst", {30'd0, rst_a, rst_b}, 32'd0);
        rd2(8'h00, 32'h0, 32'h4, "R1 mask reset");
        rd2(8'h04, 32'h0, 32'h0, "R1 autodis reset");
        rd2(8'h0C, 32'h0, 32'h0, "R1 cause reset");

        // R3: blocked at reset, then polarity of the mask bit
        wdg_req = 1;
        repeat (3) step();
        check("R3 blocked after reset", {30'd0, rst_a, rst_b}, 32'd0);
        wr(8'h00, 32'h4);
        step();
        check("R3 set bit allows (inv)", {31'd0, rst_a}, 32'd1);
        check("R3 set bit blocks (pos)", {31'd0, rst_b}, 32'd0);
        rd2(8'h0C, 32'h1, 32'h0, "R6 cause after reset out");
        wr(8'h00, 32'h0);
        step();
        check("R3 clear bit blocks (inv)", {31'd0, rst_a}, 32'd0);
        check("R3 clear bit allows (pos)", {31'd0, rst_b}, 32'd1);

        // R4: auto-disable with processor in reset
        cpu_rst = 1;
        wr(8'h04, 32'h4);
        step();
        check("R4 suppressed in cpu reset", {31'd0, rst_b}, 32'd0);
        cpu_rst = 0;
        step();
        check("R4 passes once cpu out of reset", {31'd0, rst_b}, 32'd1);
        wdg_req = 0;
        step();
        check("R5 low without request", {30'd0, rst_a, rst_b}, 32'd0);

        // R6: sticky flag, write 0 ignored, write 1 clears, set wins
        wr(8'h0C, 32'h0);
        rd2(8'h0C, 32'h1, 32'h1, "R6 write 0 keeps flag");
        wr(8'h0C, 32'h1);
        rd2(8'h0C, 32'h0, 32'h0, "R6 write 1 clears flag");
        wdg_req = 1;
        wr(8'h0C, 32'h1);
        wdg_req = 0;
        rd2(8'h0C, 32'h0, 32'h1, "R6 set wins over clear");
        wr(8'h0C, 32'h1);

        // R2: counter enable
        wr(8'h08, 32'h80);
        check("R2 cen set", {30'd0, cen_a, cen_b}, 32'd3);
        rd2(8'h08, 32'h80, 32'h80, "R7 cnten readback");
        wr(8'h08, 32'hFFFF_FF7F);
        check("R2 cen cleared by bit 7 only", {30'd0, cen_a, cen_b}, 32'd0);

        // R8: unmapped and other-bit writes
        wr(8'h10, 32'hFFFF_FFFF);
        rd2(8'h00, 32'h0, 32'h0, "R8 mask untouched");
        rd2(8'h04, 32'h4, 32'h4, "R8 autodis untouched");
        rd2(8'h10, 32'h0, 32'h0, "R7 unmapped reads zero");
        wr(8'h00, 32'hFFFF_FFFB);
        rd2(8'h00, 32'h0, 32'h0, "R8 other bits ignored");

        // Arm sequence then mixed traffic against the model
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h4);
        wr(8'h08, 32'h80);
        seed = 32'h1234_5678;
        for (int i = 0; i < 600; i++) begin
            seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
            wdg_req  = seed[0];
            cpu_rst  = seed[1];
            bus_sel  = seed[2] & seed[3];
            bus_we   = seed[4];
            bus_addr = {3'b000, seed[7:5] == 3'd7 ? 3'd4 : {1'b0, seed[6:5]}, 2'b00};
            bus_wdata = {seed[31:8], seed[15:8]};
            step();
        end
        bus_sel = 0; bus_we = 0;
        step();

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule